// File: doc/BRIEF.md
# Address Error Exception Detector

This block checks every instruction fetch and every load or store request for two kinds of address fault. The first is an access that is not aligned to its own size. The second is a reference to the kernel half of the address space while the core runs in user mode. When either fault is seen, the block raises an address error exception request. It reports an exception code that tells a fetch or load apart from a store, gives the general exception vector offset, and latches the failing virtual address into a bad-address register. Address translation and selection of the return PC are handled elsewhere.

Requests are sampled on a clock edge, and the exception outputs are valid from that edge. A two-state machine holds the exception condition. In `ST_QUIET` no exception is signalled. A faulting cycle takes transition `T_HIT` into `ST_RAISED`. Another faulting cycle takes `T_REPEAT`, which stays in `ST_RAISED`. A clean cycle takes `T_CLEAR` from either state back to `ST_QUIET`. If a fetch fault and a data fault arrive together, the fetch fault wins: its code is reported and its address is captured.

Top module: `aed_top`

## Requirements
- R1: A valid fetch whose address bits [1:0] are not 00 raises an exception with code 4, and `bad_vaddr` captures that fetch address.
- R2: A valid data access of word size (`dm_size`=2), or of the reserved size 3, which is handled as a word, raises an exception when address bits [1:0] are not 00.
- R3: A valid halfword access (`dm_size`=1) raises an exception when address bit 0 is 1. A halfword at an address with bits [1:0]=10 does not fault.
- R4: A valid byte access (`dm_size`=0) never faults on alignment, whatever its low address bits.
- R5: When `user_mode`=1, any valid fetch or data access with address bit 31 set raises an exception. When `user_mode`=0, the same address raises no exception.
- R6: `exc_code` is 4 for a faulting fetch or load (`dm_store`=0) and 5 for a faulting store (`dm_store`=1).
- R7: `exc_vector` reads 0x180 while `exc_req` is high and 0 otherwise.
- R8: If fetch and data faults occur in the same cycle, the code is 4 and `bad_vaddr` captures the fetch address.
- R9: `bad_vaddr` changes only in a cycle that raises an exception. Otherwise it holds its value.
- R10: Reset (`rst_n`=0, asynchronous) clears `exc_req`, `exc_code` and `bad_vaddr` to 0.
- R11: Outputs reflect the requests of the previous clock edge. A cycle with no fault, including any request whose valid input is low, gives `exc_req`=0 and `exc_code`=0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid | input | 1 | Instruction fetch request present |
| if_addr | input | 32 | Fetch virtual address |
| dm_valid | input | 1 | Load or store request present |
| dm_addr | input | 32 | Data virtual address |
| dm_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 treated as word |
| dm_store | input | 1 | 1 for a store, 0 for a load |
| user_mode | input | 1 | Core runs in user mode |
| exc_req | output | 1 | Address error exception request |
| exc_code | output | 5 | Exception code: 4 load or fetch, 5 store, 0 idle |
| exc_vector | output | 12 | Vector offset, 0x180 while requesting |
| bad_vaddr | output | 32 | Captured failing virtual address |

## Verification
The fetch check and the data check can both fault in the same cycle, and only one of them may set the code and the captured address. The stimulus table drives a misaligned fetch together with a misaligned store, and the bench expects code 4 and the fetch address. A neighbouring row pairs a clean fetch with the same faulting store and expects code 5 and the store address, which shows that the store is reported once the fetch no longer competes.

// File: rtl/aed_pkg.sv
package aed_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_t;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } aed_state_t;

    localparam int               CODE_W      = 5;
    localparam logic [CODE_W-1:0] CODE_NONE  = 5'd0;
    localparam logic [CODE_W-1:0] CODE_LOAD  = 5'd4;
    localparam logic [CODE_W-1:0] CODE_STORE = 5'd5;

    localparam int               VEC_W       = 12;
    localparam logic [VEC_W-1:0] VEC_GENERAL = 12'h180;

    localparam int NPORT    = 2;
    localparam int PORT_IF  = 0;
    localparam int PORT_DM  = 1;

endpackage

// File: rtl/aed_chk.sv
module aed_chk
    import aed_pkg::*;
(
    input  logic      req_valid,
    input  logic [1:0] req_lsb,
    input  logic      req_msb,
    input  acc_size_t req_size,
    input  logic      user_mode,
    output logic      fault
);

    logic misalign;
    logic priv_fault;

    always_comb begin
        unique case (req_size)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = req_lsb[0];
            default: misalign = (req_lsb != 2'b00);
        endcase
    end

    assign priv_fault = user_mode && req_msb;
    assign fault      = req_valid && (misalign || priv_fault);

endmodule

// File: rtl/aed_sel.sv
module aed_sel
    import aed_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              f_fault,
    input  logic [ADDR_W-1:0] f_addr,
    input  logic              d_fault,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic              d_store,
    output logic              any_fault,
    output logic [CODE_W-1:0] sel_code,
    output logic [ADDR_W-1:0] sel_addr
);

    assign any_fault = f_fault || d_fault;

    always_comb begin
        if (f_fault) begin
            sel_code = CODE_LOAD;
            sel_addr = f_addr;
        end else if (d_fault) begin
            sel_code = d_store ? CODE_STORE : CODE_LOAD;
            sel_addr = d_addr;
        end else begin
            sel_code = CODE_NONE;
            sel_addr = '0;
        end
    end

endmodule

// File: rtl/aed_top.sv
module aed_top
    import aed_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_valid,
    input  logic [ADDR_W-1:0] if_addr,
    input  logic              dm_valid,
    input  logic [ADDR_W-1:0] dm_addr,
    input  logic [1:0]        dm_size,
    input  logic              dm_store,
    input  logic              user_mode,
    output logic              exc_req,
    output logic [CODE_W-1:0] exc_code,
    output logic [VEC_W-1:0]  exc_vector,
    output logic [ADDR_W-1:0] bad_vaddr
);

    localparam int MSB = ADDR_W - 1;

    logic [NPORT-1:0] chk_valid;
    logic [1:0]       chk_lsb  [NPORT];
    logic [NPORT-1:0] chk_msb;
    acc_size_t        chk_size [NPORT];
    logic [NPORT-1:0] chk_fault;

    assign chk_valid[PORT_IF] = if_valid;
    assign chk_lsb[PORT_IF]   = if_addr[1:0];
    assign chk_msb[PORT_IF]   = if_addr[MSB];
    assign chk_size[PORT_IF]  = SZ_WORD;

    assign chk_valid[PORT_DM] = dm_valid;
    assign chk_lsb[PORT_DM]   = dm_addr[1:0];
    assign chk_msb[PORT_DM]   = dm_addr[MSB];
    assign chk_size[PORT_DM]  = acc_size_t'(dm_size);

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        aed_chk u_chk (
            .req_valid (chk_valid[p]),
            .req_lsb   (chk_lsb[p]),
            .req_msb   (chk_msb[p]),
            .req_size  (chk_size[p]),
            .user_mode (user_mode),
            .fault     (chk_fault[p])
        );
    end

    logic              any_fault;
    logic [CODE_W-1:0] sel_code;
    logic [ADDR_W-1:0] sel_addr;

    aed_sel #(.ADDR_W(ADDR_W)) u_sel (
        .f_fault   (chk_fault[PORT_IF]),
        .f_addr    (if_addr),
        .d_fault   (chk_fault[PORT_DM]),
        .d_addr    (dm_addr),
        .d_store   (dm_store),
        .any_fault (any_fault),
        .sel_code  (sel_code),
        .sel_addr  (sel_addr)
    );

    // State machine: T_HIT / T_REPEAT on a fault, T_CLEAR otherwise
    aed_state_t state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_QUIET:  state_d = any_fault ? ST_RAISED : ST_QUIET;
            ST_RAISED: state_d = any_fault ? ST_RAISED : ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // Output registers: code tracks every cycle, address only on a fault
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exc_code  <= CODE_NONE;
            bad_vaddr <= '0;
        end else if (any_fault) begin
            exc_code  <= sel_code;
            bad_vaddr <= sel_addr;
        end else begin
            exc_code  <= CODE_NONE;
        end
    end

    assign exc_req    = (state_q == ST_RAISED);
    assign exc_vector = exc_req ? VEC_GENERAL : '0;

    assert_fetch_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (if_valid && if_addr[1:0] != 2'b00) |=>
        (exc_req && exc_code == CODE_LOAD && bad_vaddr == $past(if_addr)));

    assert_word_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_valid && dm_size[1] && dm_addr[1:0] != 2'b00) |=> exc_req);

    assert_half_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_valid && dm_size == SZ_HALF && dm_addr[0]) |=> exc_req);

    assert_byte_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_fault[PORT_IF] && dm_valid && dm_size == SZ_BYTE &&
         !(user_mode && dm_addr[MSB])) |=> !exc_req);

    assert_kernel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_valid && user_mode && dm_addr[MSB]) |=> exc_req);

    assert_store_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_fault[PORT_IF] && chk_fault[PORT_DM] && dm_store) |=>
        (exc_code == CODE_STORE));

    assert_fetch_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_fault[PORT_IF] && chk_fault[PORT_DM]) |=>
        (exc_code == CODE_LOAD && bad_vaddr == $past(if_addr)));

    assert_bad_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_fault |=> $stable(bad_vaddr));

    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !any_fault |=> (!exc_req && exc_code == CODE_NONE));

endmodule

// File: tb/sim_aed_top.sv
module sim_aed_top;
    import aed_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_valid = 1'b0;
    logic [31:0] if_addr = '0;
    logic        dm_valid = 1'b0;
    logic [31:0] dm_addr = '0;
    logic [1:0]  dm_size = '0;
    logic        dm_store = 1'b0;
    logic        user_mode = 1'b0;
    logic        exc_req;
    logic [4:0]  exc_code;
    logic [11:0] exc_vector;
    logic [31:0] bad_vaddr;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    aed_top u0 (
        .clk(clk), .rst_n(rst_n),
        .if_valid(if_valid), .if_addr(if_addr),
        .dm_valid(dm_valid), .dm_addr(dm_addr), .dm_size(dm_size),
        .dm_store(dm_store), .user_mode(user_mode),
        .exc_req(exc_req), .exc_code(exc_code),
        .exc_vector(exc_vector), .bad_vaddr(bad_vaddr)
    );

    typedef struct packed {
        logic        ifv;
        logic [31:0] ifa;
        logic        dv;
        logic [31:0] da;
        logic [1:0]  sz;
        logic        st;
        logic        usr;
        logic        ereq;
        logic [4:0]  ecode;
        logic        esel;   // 1: captured address is the fetch address
    } row_t;

    localparam int NROW = 20;
    localparam row_t TBL [NROW] = '{
        '{1'b1, 32'h0000_1000, 1'b0, 32'h0,         2'd2, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b1, 32'h0000_1002, 1'b0, 32'h0,         2'd2, 1'b0, 1'b0, 1'b1, 5'd4, 1'b1},
        '{1'b1, 32'h0000_1001, 1'b0, 32'h0,         2'd2, 1'b0, 1'b0, 1'b1, 5'd4, 1'b1},
        '{1'b0, 32'h0,         1'b1, 32'h0000_2004, 2'd2, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b0, 32'h0,         1'b1, 32'h0000_2006, 2'd2, 1'b0, 1'b0, 1'b1, 5'd4, 1'b0},
        '{1'b0, 32'h0,         1'b1, 32'h0000_2003, 2'd2, 1'b1, 1'b0, 1'b1, 5'd5, 1'b0},
        '{1'b0, 32'h0,         1'b1, 32'h0000_3002, 2'd1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b0, 32'h0,         1'b1, 32'h0000_3001, 2'd1, 1'b0, 1'b0, 1'b1, 5'd4, 1'b0},
        '{1'b0, 32'h0,         1'b1, 32'h0000_3005, 2'd1, 1'b1, 1'b0, 1'b1, 5'd5, 1'b0},
        '{1'b0, 32'h0,         1'b1, 32'h0000_4003, 2'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b0, 32'h0,         1'b1, 32'h0000_4001, 2'd0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b0, 32'h0,         1'b1, 32'h8000_0000, 2'd2, 1'b0, 1'b1, 1'b1, 5'd4, 1'b0},
        '{1'b0, 32'h0,         1'b1, 32'h8000_0001, 2'd0, 1'b1, 1'b1, 1'b1, 5'd5, 1'b0},
        '{1'b0, 32'h0,         1'b1, 32'h8000_0010, 2'd2, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b1, 32'h8000_0100, 1'b0, 32'h0,         2'd2, 1'b0, 1'b1, 1'b1, 5'd4, 1'b1},
        '{1'b1, 32'h0000_1006, 1'b1, 32'h0000_2001, 2'd2, 1'b1, 1'b0, 1'b1, 5'd4, 1'b1},
        '{1'b1, 32'h0000_1000, 1'b1, 32'h0000_2001, 2'd2, 1'b1, 1'b0, 1'b1, 5'd5, 1'b0},
        '{1'b0, 32'h0,         1'b0, 32'h0000_2001, 2'd2, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b1, 32'h0000_0004, 1'b1, 32'h7FFF_FFFF, 2'd0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0},
        '{1'b0, 32'h0,         1'b1, 32'h0000_2002, 2'd3, 1'b0, 1'b0, 1'b1, 5'd4, 1'b0}
    };

    localparam string TAGS [NROW] = '{
        "R11", "R1", "R1", "R2", "R2", "R6", "R3", "R3", "R6", "R4",
        "R4", "R5", "R5", "R5", "R5", "R8", "R8", "R11", "R4", "R2"
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic ereq,
                             input logic [4:0] ecode, input logic [31:0] ebad);
        check(tag, "exc_req",    {31'd0, exc_req},     {31'd0, ereq});
        check(tag, "exc_code",   {27'd0, exc_code},    {27'd0, ecode});
        check("R7", "exc_vector", {20'd0, exc_vector}, ereq ? 32'h180 : 32'h0);
        check(tag, "bad_vaddr",  bad_vaddr,            ebad);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] exp_bad;
        exp_bad = '0;

        // R10: reset state
        repeat (3) @(negedge clk);
        check_all("R10", 1'b0, 5'd0, 32'h0);
        rst_n = 1'b1;

        // Table walk: drive on one falling edge, check on the next
        for (int i = 0; i < NROW; i++) begin
            @(negedge clk);
            if_valid  = TBL[i].ifv;
            if_addr   = TBL[i].ifa;
            dm_valid  = TBL[i].dv;
            dm_addr   = TBL[i].da;
            dm_size   = TBL[i].sz;
            dm_store  = TBL[i].st;
            user_mode = TBL[i].usr;
            if (TBL[i].ereq) exp_bad = TBL[i].esel ? TBL[i].ifa : TBL[i].da;
            @(negedge clk);
            check_all(TAGS[i], TBL[i].ereq, TBL[i].ecode, exp_bad);
        end

        // R9 / R11: idle cycles keep the captured address, drop request
        if_valid = 1'b0;
        dm_valid = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R9", 1'b0, 5'd0, exp_bad);

        // R5: kernel-space fetch outside user mode is accepted
        if_valid  = 1'b1;
        if_addr   = 32'h8000_0200;
        user_mode = 1'b0;
        @(negedge clk);
        check_all("R5", 1'b0, 5'd0, exp_bad);

        // R11: fault then immediate clean cycle
        if_addr = 32'h0000_0003;
        @(negedge clk);
        check_all("R11", 1'b1, 5'd4, 32'h0000_0003);
        if_addr = 32'h0000_0008;
        @(negedge clk);
        check_all("R11", 1'b0, 5'd0, 32'h0000_0003);

        // R10: asynchronous reset in the middle of a run
        if_addr = 32'h0000_0005;
        @(negedge clk);
        check_all("R1", 1'b1, 5'd4, 32'h0000_0005);
        rst_n = 1'b0;
        #1;
        check_all("R10", 1'b0, 5'd0, 32'h0);
        if_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R10", 1'b0, 5'd0, 32'h0);

        finish_run();
    end

endmodule